// File: doc/BRIEF.md
# Oversampling Receive Clock Recovery

This block rebuilds a receive bit clock from a serial data line. It is clocked by a reference that runs at sixteen times the nominal bit rate. The raw line is first cleaned by a short majority-vote filter, and every change of the filtered level is taken as the boundary of a new bit cell. A four-bit phase counter counts through the cell. Each boundary nudges the counter by one count toward alignment, so the falling edge of the recovered clock settles in the middle of the cell. At that falling edge a one-cycle strobe marks when the filtered bit is valid.

The block also supplies a transmit clock. A select input picks either a plain divide-by-sixteen of the reference or the recovered receive clock. After reset the recovered clock is held high and no strobes are issued until the first data transition arrives.

Top module: `dpll_rx_clk`

## Requirements
- R1: With no data transitions, a locked block issues sample strobes exactly 16 reference cycles apart and so keeps the last phase.
- R2: The filtered data is the majority of the last three reference-rate samples of `rxRaw`. A pulse of one reference cycle on the line is rejected and causes neither a transition nor lock.
- R3: After reset `rxClk` stays high and `sampleStrobe` stays low until the first filtered transition. A line change applied before reference edge k becomes a transition after edge k+1, and the first strobe follows 8 cycles later.
- R4: Phase counts 0 to 7 drive `rxClk` high and counts 8 to 15 drive it low. `sampleStrobe` is high for exactly one cycle, in the cycle where `rxClk` has just fallen.
- R5: A transition seen at phase count 8 to 15 makes the counter step by 2 instead of 1, so the strobe interval becomes 15.
- R6: A transition seen at count 1 to 7 makes the counter hold for one cycle, so the interval becomes 17. A transition at count 0 leaves the interval at 16.
- R7: With `txSel`=0, `txClk` is a divide-by-16 of the reference that is high for 8 cycles and then low for 8, counted from reset. With `txSel`=1, `txClk` follows `rxClk`.
- R8: `sampleBit` is the filtered data value. It is the bit to take whenever `sampleStrobe` is high.
- R9: A synchronous reset, active high, clears the filter, the phase counter and the lock, and forces both clocks high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| rxRaw | input | 1 | Raw serial receive data |
| txSel | input | 1 | Transmit clock source: 0 divided reference, 1 recovered clock |
| rxClk | output | 1 | Recovered receive clock |
| txClk | output | 1 | Selected transmit clock |
| sampleStrobe | output | 1 | One-cycle pulse at each falling edge of rxClk |
| sampleBit | output | 1 | Filtered data bit, valid with sampleStrobe |

## Verification
Several properties are checked on every cycle. The strobe lasts one cycle, it coincides with a falling edge of the recovered clock, every falling edge carries a strobe, and the clocks are high right after reset. Other behaviour depends on where a transition lands within the cell, and only the bench scenarios can show it. These are the step-by-two and hold corrections, glitch rejection, the first-lock latency and the sixteen-cycle free run. For these, the bench places edges at chosen phases and measures strobe intervals. It also runs a reference model against jittered random data.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  // per-cycle command from control to datapath
  typedef struct packed {
    logic inc;    // normal one-count step
    logic extra;  // additional step when lagging
  } phaseCmd_t;
endpackage

// File: rtl/dpll_ctrl.sv
module dpll_ctrl
  import dpll_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            edgeSeen,
  input  logic [PH_W-1:0] phase,
  output phaseCmd_t       cmd,
  output logic            locked
);
  localparam logic [PH_W-1:0] HALF = PH_W'(1 << (PH_W - 1));

  logic earlyHalf, lateHalf;

  assign lateHalf  = (phase >= HALF);
  assign earlyHalf = (phase != '0) && !lateHalf;

  always_ff @(posedge clk) begin
    if (rst)           locked <= 1'b0;
    else if (edgeSeen) locked <= 1'b1;
  end

  always_comb begin
    cmd = '0;
    if (!locked) begin
      // counter parked at 0; first edge defines count 0
      cmd.inc = edgeSeen;
    end else if (edgeSeen && earlyHalf) begin
      cmd.inc = 1'b0;            // running ahead: hold
    end else if (edgeSeen && lateHalf) begin
      cmd.inc   = 1'b1;          // lagging: step twice
      cmd.extra = 1'b1;
    end else begin
      cmd.inc = 1'b1;
    end
  end
endmodule

// File: rtl/dpll_dp.sv
module dpll_dp
  import dpll_pkg::*;
#(
  parameter int PH_W = 4,
  parameter int TAPS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rxRaw,
  input  logic            txSel,
  input  phaseCmd_t       cmd,
  input  logic            locked,
  output logic            edgeSeen,
  output logic [PH_W-1:0] phase,
  output logic            rxClk,
  output logic            txClk,
  output logic            sampleStrobe,
  output logic            sampleBit
);
  localparam logic [PH_W-1:0] HALF = PH_W'(1 << (PH_W - 1));
  localparam int VOTE_MIN = TAPS / 2 + 1;

  logic [TAPS-1:0] taps;
  logic            filtered, filtPrev;
  logic [PH_W-1:0] txDiv;

  // interference rejection: majority of the last TAPS samples
  always_ff @(posedge clk) begin
    if (rst) begin
      taps     <= '0;
      filtPrev <= 1'b0;
    end else begin
      taps     <= {taps[TAPS-2:0], rxRaw};
      filtPrev <= filtered;
    end
  end

  assign filtered = ($countones(taps) >= VOTE_MIN);
  assign edgeSeen = filtered ^ filtPrev;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + PH_W'(cmd.inc) + PH_W'(cmd.extra);
  end

  always_ff @(posedge clk) begin
    if (rst) txDiv <= '0;
    else     txDiv <= txDiv + 1'b1;
  end

  assign rxClk        = !locked || (phase < HALF);
  assign sampleStrobe = locked && (phase == HALF);
  assign sampleBit    = filtered;
  assign txClk        = txSel ? rxClk : (txDiv < HALF);
endmodule

// File: rtl/dpll_rx_clk.sv
module dpll_rx_clk
  import dpll_pkg::*;
#(
  parameter int PH_W = 4,
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rxRaw,
  input  logic txSel,
  output logic rxClk,
  output logic txClk,
  output logic sampleStrobe,
  output logic sampleBit
);
  phaseCmd_t       cmd;
  logic            locked;
  logic            edgeSeen;
  logic [PH_W-1:0] phase;

  dpll_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clk(clk), .rst(rst), .edgeSeen(edgeSeen), .phase(phase),
    .cmd(cmd), .locked(locked)
  );

  dpll_dp #(.PH_W(PH_W), .TAPS(TAPS)) u_dp (
    .clk(clk), .rst(rst), .rxRaw(rxRaw), .txSel(txSel),
    .cmd(cmd), .locked(locked), .edgeSeen(edgeSeen), .phase(phase),
    .rxClk(rxClk), .txClk(txClk), .sampleStrobe(sampleStrobe),
    .sampleBit(sampleBit)
  );
endmodule

// File: rtl/dpll_chk.sv
module dpll_chk (
  input logic clk,
  input logic rst,
  input logic rxClk,
  input logic txClk,
  input logic sampleStrobe
);
  // R4: strobe only at a falling edge of the recovered clock
  a_r4_strobe_at_fall: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |-> ($past(rxClk) && !rxClk));

  // R4: every falling edge carries a strobe
  a_r4_fall_has_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(rxClk) |-> sampleStrobe);

  // R4: strobe is a single-cycle pulse
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |=> !sampleStrobe);

  // R9: reset leaves both clocks high and no strobe
  a_r9_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (rxClk && txClk && !sampleStrobe));
endmodule

bind dpll_rx_clk dpll_chk u_chk (
  .clk(clk), .rst(rst), .rxClk(rxClk), .txClk(txClk),
  .sampleStrobe(sampleStrobe)
);

// File: tb/tb_dpll_rx_clk.sv
module tb_dpll_rx_clk;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxRaw = 1'b0;
  logic txSel = 1'b0;
  logic rxClk, txClk, sampleStrobe, sampleBit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit [2:0] mTaps;
  bit       mPrev, mLock;
  bit [3:0] mPh, mTx;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpll_rx_clk dut (
    .clk(clk), .rst(rst), .rxRaw(rxRaw), .txSel(txSel),
    .rxClk(rxClk), .txClk(txClk), .sampleStrobe(sampleStrobe),
    .sampleBit(sampleBit)
  );

  function automatic bit maj3(bit [2:0] t);
    return (t[0] & t[1]) | (t[0] & t[2]) | (t[1] & t[2]);
  endfunction

  function automatic bit expRx();
    return !mLock || (mPh < 8);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model update for one reference edge with input d
  task automatic modelEdge(bit d);
    bit f, e;
    if (rst) begin
      mTaps = 0; mPrev = 0; mLock = 0; mPh = 0; mTx = 0;
    end else begin
      f = maj3(mTaps);
      e = f != mPrev;
      if (!mLock)                      mPh = e ? 4'd1 : 4'd0;
      else if (e && mPh >= 1 && mPh <= 7) mPh = mPh;
      else if (e && mPh >= 8)          mPh = mPh + 4'd2;
      else                             mPh = mPh + 4'd1;
      if (e) mLock = 1;
      mTx   = mTx + 4'd1;
      mPrev = f;
      mTaps = {mTaps[1:0], d};
    end
  endtask

  // drive, clock once, compare at the falling edge
  task automatic step(bit d, bit sel);
    bit eRx;
    rxRaw = d;
    txSel = sel;
    @(posedge clk);
    modelEdge(d);
    @(negedge clk);
    eRx = expRx();
    check(rxClk == eRx, "R4 rxClk", rxClk, eRx);
    check(sampleStrobe == (mLock && mPh == 8), "R4 strobe", sampleStrobe, mLock && mPh == 8);
    check(sampleBit == maj3(mTaps), "R8 sampleBit", sampleBit, maj3(mTaps));
    check(txClk == (sel ? eRx : (mTx < 8)), "R7 txClk", txClk, sel ? eRx : (mTx < 8));
  endtask

  task automatic doReset();
    rst = 1;
    step(0, 0);
    step(0, 0);
    rst = 0;
  endtask

  // hold line until a strobe appears; returns cycles taken
  task automatic runToStrobe(bit d, output int n);
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      step(d, 0);
      if (sampleStrobe) begin n = i; return; end
    end
  endtask

  // after a strobe, change the line at step m; return interval to next strobe
  task automatic edgeInterval(bit cur, int m, output int n);
    n = 0;
    for (int j = 1; j <= 40; j++) begin
      step((j >= m) ? !cur : cur, 0);
      if (sampleStrobe) begin n = j; return; end
    end
  endtask

  initial begin
    int n;
    int cntStrobe;
    bit hiAll;
    bit lvl;
    bit s;
    void'($urandom(1234));

    // R9 reset state
    doReset();
    check(rxClk == 1, "R9 rxClk after reset", rxClk, 1);
    check(txClk == 1, "R9 txClk after reset", txClk, 1);
    check(sampleStrobe == 0, "R9 strobe after reset", sampleStrobe, 0);

    // R2 + R3: single-cycle glitch is rejected, no lock
    cntStrobe = 0; hiAll = 1;
    step(1, 0);
    for (int i = 0; i < 24; i++) begin
      step(0, 0);
      if (sampleStrobe) cntStrobe++;
      if (!rxClk) hiAll = 0;
    end
    check(cntStrobe == 0, "R2 glitch gives no strobe", cntStrobe, 0);
    check(hiAll == 1, "R3 rxClk held high while unlocked", hiAll, 1);
    check(sampleBit == 0, "R2 glitch filtered out", sampleBit, 0);

    // R3: first strobe 10 edges after line change
    runToStrobe(1, n);
    check(n == 10, "R3 first lock latency", n, 10);

    // R1: free run at 16 with no transitions
    runToStrobe(1, n);
    check(n == 16, "R1 free-run interval", n, 16);
    runToStrobe(1, n);
    check(n == 16, "R1 free-run interval repeat", n, 16);

    // R5: edge at count 12 -> interval 15
    edgeInterval(1, 3, n);
    check(n == 15, "R5 late-half advance", n, 15);
    // line now 0; R6: edge at count 3 -> interval 17
    edgeInterval(0, 10, n);
    check(n == 17, "R6 early-half hold", n, 17);
    // R6: edge at count 0 -> interval 16
    edgeInterval(1, 7, n);
    check(n == 16, "R6 count-0 no correction", n, 16);
    // R8: sampled bit equals settled line (0)
    check(sampleBit == 0, "R8 bit at strobe", sampleBit, 0);

    // R7: recovered clock as transmit clock
    step(0, 1);
    check(txClk == rxClk, "R7 txSel=1 follows rxClk", txClk, rxClk);

    // random jittered data with occasional glitches, model compared each cycle
    lvl = 0;
    for (int c = 0; c < 400; c++) begin
      int len;
      bit b;
      len = 15 + int'($urandom_range(0, 2));
      b = $urandom_range(0, 1);
      s = $urandom_range(0, 1);
      for (int k = 0; k < len; k++) begin
        bit d;
        d = b;
        if (k == 6 && $urandom_range(0, 9) == 0) d = !b;
        step(d, s);
      end
      lvl = b;
    end

    // R9 mid-run reset
    doReset();
    check(rxClk == 1 && txClk == 1 && sampleStrobe == 0, "R9 reset mid-run",
          {rxClk, txClk, sampleStrobe}, 3'b110);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule